// File: doc/BRIEF.md
# Burst pulse pattern sequencer

This block generates the logic-level control for one bipolar high-voltage pulser channel: a positive drive, a negative drive, a driver enable and a clamp control. While `run` is high it fires a trigger on its own every `TRIG_CYCLES` clock cycles (50 µs at the default 50 MHz clock). At each trigger it captures the pattern select, the repeat count and the rate divider. It then plays a burst of one to four pattern repeats. Each pulse phase lasts one rate tick, and one rate tick is `rate_div + 1` clock cycles.

Patterns 0 and 1 are non-return-to-zero: the enable is high for the whole burst and the two drives alternate. Pattern 0 starts positive and pattern 1 starts negative. Patterns 2 and 3 are return-to-zero: a clamp phase follows every pulse, and pattern 2 starts positive while pattern 3 starts negative. Pattern 4 is continuous. The drives alternate on every tick without regard to the trigger period or the repeat count, and the enable becomes a slow square wave that is high for the first tenth of each `CW_PERIOD` cycles. Codes 5 to 7 are reserved and produce no output. Dropping `run` clears all state and holds every output low.

Top module: `burst_pulse_seq`

## Requirements
- R1: While `run` is high, a trigger fires on the first cycle with `run` high and then every `TRIG_CYCLES` cycles. A burst that is accepted at a trigger shows its first pulse in the cycle right after that trigger edge.
- R2: A burst contains `repeat_sel + 1` repeats of the captured pattern (`repeat_sel` = 0..3 gives 1..4 repeats).
- R3: For `wave_sel` 0 and 1, each repeat is two phases, one positive and one negative, and `drv_en` is high for exactly the burst duration. Code 0 drives `drv_pos` first and code 1 drives `drv_neg` first. `clamp_on` stays low.
- R4: For `wave_sel` 2 and 3, each repeat is four phases: pulse, clamp, opposite pulse, clamp. `clamp_on` is high only in the clamp phases, `drv_en` covers the burst, code 2 starts positive and code 3 starts negative.
- R5: For `wave_sel` 4, the two drives alternate each tick, starting positive, and run without a break across trigger boundaries, whatever `repeat_sel` is.
- R6: For `wave_sel` 4, `drv_en` is high for the first `CW_PERIOD/10` cycles of each `CW_PERIOD`-cycle window, counted from entry into the mode.
- R7: Every phase lasts `rate_div + 1` cycles, and `drv_pos` and `drv_neg` are never high in the same cycle.
- R8: With `run` low, or with a reserved `wave_sel` (5, 6, 7) captured, all four outputs are low one edge later.
- R9: Settings are captured only at an accepted trigger. A change made during a burst does not alter that burst, and a trigger that arrives while a burst is still running is dropped.
- R10: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High to run; low stops and clears |
| wave_sel | input | 3 | Pattern code (0..4, 5..7 reserved) |
| rate_div | input | DIV_W | Phase length minus one, in clocks |
| repeat_sel | input | 2 | Repeats per burst minus one |
| drv_pos | output | 1 | Positive drive |
| drv_neg | output | 1 | Negative drive |
| drv_en | output | 1 | Driver enable |
| clamp_on | output | 1 | Clamp control |

## Verification
Two events can fall in the same cycle here: a new trigger and a burst that is still running. The bench provokes this with a return-to-zero burst of 256 cycles against a 200-cycle trigger period. The enable must stay high for exactly 256 cycles in a 400-cycle window, and the next burst must begin at cycle 401, which shows that the mid-burst trigger was dropped and not restarted. A settings change made five cycles into a burst is judged in the same way: the pulse counts of the running burst must be unaffected, and the new pattern must appear only after the next trigger.

// File: rtl/burst_pulse_seq.sv
module burst_pulse_seq #(
  parameter int TRIG_CYCLES = 2500,
  parameter int CW_PERIOD   = 5_000_000,
  parameter int DIV_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [2:0]       wave_sel,
  input  logic [DIV_W-1:0] rate_div,
  input  logic [1:0]       repeat_sel,
  output logic             drv_pos,
  output logic             drv_neg,
  output logic             drv_en,
  output logic             clamp_on
);
  localparam int TW    = $clog2(TRIG_CYCLES);
  localparam int EW    = $clog2(CW_PERIOD);
  localparam int CW_ON = CW_PERIOD / 10;
  localparam logic [2:0] M_A = 3'd0, M_B = 3'd1, M_C = 3'd2, M_D = 3'd3, M_E = 3'd4, M_IDLE = 3'd7;

  logic [TW-1:0]    trig_cnt;
  logic [2:0]       mode;
  logic [1:0]       reps;
  logic [DIV_W-1:0] div, div_cnt;
  logic             busy, cw_tgl;
  logic [3:0]       ph, last_ph;
  logic [EW-1:0]    en_cnt;
  logic             trig, take, cw, nrz, rz, inv, tick, first, second;

  assign trig    = run && (trig_cnt == '0);
  assign take    = trig && !busy;
  assign cw      = (mode == M_E);
  assign nrz     = (mode == M_A) || (mode == M_B);
  assign rz      = (mode == M_C) || (mode == M_D);
  assign inv     = (mode == M_B) || (mode == M_D);
  assign tick    = (busy || cw) && (div_cnt >= div);
  assign last_ph = nrz ? {1'b0, reps, 1'b1} : {reps, 2'b11};
  assign first   = nrz ? !ph[0] : (ph[1:0] == 2'd0);
  assign second  = nrz ?  ph[0] : (ph[1:0] == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_cnt <= '0; mode <= M_IDLE; reps <= '0; div <= '0; div_cnt <= '0;
      busy <= 1'b0; ph <= '0; cw_tgl <= 1'b0; en_cnt <= '0;
    end else if (!run) begin
      trig_cnt <= '0; mode <= M_IDLE; reps <= '0; div <= '0; div_cnt <= '0;
      busy <= 1'b0; ph <= '0; cw_tgl <= 1'b0; en_cnt <= '0;
    end else begin
      trig_cnt <= (trig_cnt == TW'(TRIG_CYCLES - 1)) ? '0 : trig_cnt + 1'b1;
      if (tick)              div_cnt <= '0;
      else if (busy || cw)   div_cnt <= div_cnt + 1'b1;
      if (busy && tick) begin
        if (ph == last_ph) busy <= 1'b0;
        else               ph   <= ph + 1'b1;
      end
      if (cw) begin
        en_cnt <= (en_cnt == EW'(CW_PERIOD - 1)) ? '0 : en_cnt + 1'b1;
        if (tick) cw_tgl <= !cw_tgl;
      end
      if (take) begin
        mode <= wave_sel;
        reps <= repeat_sel;
        div  <= rate_div;
        if (wave_sel <= M_D) begin
          busy <= 1'b1; ph <= '0; div_cnt <= '0;
        end
        if (wave_sel == M_E && !cw) begin
          cw_tgl <= 1'b0; en_cnt <= '0; div_cnt <= '0;
        end
      end
    end
  end

  assign drv_pos  = (busy && (inv ? second : first)) || (cw && !cw_tgl);
  assign drv_neg  = (busy && (inv ? first : second)) || (cw &&  cw_tgl);
  assign clamp_on = busy && rz && ph[0];
  assign drv_en   = busy || (cw && (en_cnt < EW'(CW_ON)));
endmodule

// File: rtl/burst_pulse_seq_chk.sv
module burst_pulse_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic drv_pos,
  input logic drv_neg,
  input logic drv_en,
  input logic clamp_on
);
  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n) !(drv_pos && drv_neg));
  p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !(drv_pos || drv_neg || drv_en || clamp_on));
  p_runonly_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_pos || drv_neg || drv_en || clamp_on) |-> $past(run));
  p_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_on |-> (drv_en && !drv_pos && !drv_neg));
  p_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(clamp_on) && run && $past(run)) |-> (drv_pos || drv_neg || !drv_en));
endmodule

bind burst_pulse_seq burst_pulse_seq_chk u_chk (.*);

// File: tb/test_burst_pulse_seq.sv
module test_burst_pulse_seq;
  localparam int TRIG = 200;
  localparam int CWP  = 400;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0;
  logic [2:0] wave_sel = '0;
  logic [7:0] rate_div = '0;
  logic [1:0] repeat_sel = '0;
  logic drv_pos, drv_neg, drv_en, clamp_on;

  burst_pulse_seq #(.TRIG_CYCLES(TRIG), .CW_PERIOD(CWP), .DIV_W(8)) i_burst_pulse_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .wave_sel(wave_sel), .rate_div(rate_div),
    .repeat_sel(repeat_sel), .drv_pos(drv_pos), .drv_neg(drv_neg), .drv_en(drv_en),
    .clamp_on(clamp_on));

  always #10 clk = ~clk;

  typedef struct packed {
    logic [2:0] w; logic [1:0] r; logic [7:0] d;
    logic [8:0] p, n, c, e; logic [1:0] f;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{3'd0, 2'd0, 8'd0,   9'd1,   9'd1,  9'd0,  9'd2, 2'd1},
    '{3'd0, 2'd3, 8'd2,  9'd12,  9'd12,  9'd0, 9'd24, 2'd1},
    '{3'd1, 2'd1, 8'd1,   9'd4,   9'd4,  9'd0,  9'd8, 2'd2},
    '{3'd1, 2'd2, 8'd3,  9'd12,  9'd12,  9'd0, 9'd24, 2'd2},
    '{3'd2, 2'd0, 8'd1,   9'd2,   9'd2,  9'd4,  9'd8, 2'd1},
    '{3'd2, 2'd3, 8'd3,  9'd16,  9'd16, 9'd32, 9'd64, 2'd1},
    '{3'd3, 2'd1, 8'd0,   9'd2,   9'd2,  9'd4,  9'd8, 2'd2},
    '{3'd3, 2'd2, 8'd2,   9'd9,   9'd9, 9'd18, 9'd36, 2'd2},
    '{3'd4, 2'd0, 8'd1, 9'd100, 9'd100,  9'd0, 9'd40, 2'd1},
    '{3'd4, 2'd3, 8'd1, 9'd100, 9'd100,  9'd0, 9'd40, 2'd1},
    '{3'd4, 2'd0, 8'd4, 9'd100, 9'd100,  9'd0, 9'd40, 2'd1},
    '{3'd5, 2'd1, 8'd1,   9'd0,   9'd0,  9'd0,  9'd0, 2'd0},
    '{3'd7, 2'd2, 8'd0,   9'd0,   9'd0,  9'd0,  9'd0, 2'd0}
  };

  int checks = 0, failures = 0;
  int n_pos, n_neg, n_clp, n_en, n_both, first_code;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int code_now();
    return drv_pos ? 1 : (drv_neg ? 2 : 0);
  endfunction

  function automatic string tag_of(input logic [2:0] w);
    if (w <= 3'd1) return "R2 R3 R7";
    if (w <= 3'd3) return "R2 R4 R7";
    if (w == 3'd4) return "R5 R6";
    return "R8";
  endfunction

  task automatic clr();
    n_pos = 0; n_neg = 0; n_clp = 0; n_en = 0; n_both = 0; first_code = -1;
  endtask

  task automatic measure(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (first_code < 0) first_code = code_now();
      n_pos += int'(drv_pos); n_neg += int'(drv_neg);
      n_clp += int'(clamp_on); n_en += int'(drv_en);
      n_both += int'(drv_pos && drv_neg);
    end
  endtask

  task automatic start(input logic [2:0] w, input logic [1:0] r, input logic [7:0] d);
    @(negedge clk); run = 1'b0;
    @(negedge clk); wave_sel = w; repeat_sel = r; rate_div = d; run = 1'b1;
    clr();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #5;
    chk({drv_pos, drv_neg, drv_en, clamp_on} == 4'b0, "R10 reset", {drv_pos, drv_neg, drv_en, clamp_on}, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    foreach (VECS[k]) begin
      start(VECS[k].w, VECS[k].r, VECS[k].d);
      measure(TRIG);
      chk(n_pos == VECS[k].p, {tag_of(VECS[k].w), " pos"}, n_pos, VECS[k].p);
      chk(n_neg == VECS[k].n, {tag_of(VECS[k].w), " neg"}, n_neg, VECS[k].n);
      chk(n_clp == VECS[k].c, {tag_of(VECS[k].w), " clamp"}, n_clp, VECS[k].c);
      chk(n_en  == VECS[k].e, {tag_of(VECS[k].w), " en"}, n_en, VECS[k].e);
      chk(first_code == int'(VECS[k].f), {tag_of(VECS[k].w), " order"}, first_code, VECS[k].f);
      chk(n_both == 0, "R7 overlap", n_both, 0);
      measure(1);
      chk(code_now() == int'(VECS[k].f), "R1 next trigger", code_now(), VECS[k].f);
    end

    // R9: settings change mid burst leaves it intact, new pattern at next trigger
    start(3'd0, 2'd3, 8'd3);
    measure(5);
    wave_sel = 3'd3; repeat_sel = 2'd0; rate_div = 8'd0;
    measure(TRIG - 5);
    chk(n_pos == 16 && n_neg == 16 && n_clp == 0, "R9 burst kept", n_pos + n_neg + n_clp, 32);
    clr();
    measure(TRIG);
    chk(first_code == 2 && n_clp == 2 && n_en == 4, "R9 new pattern", n_en, 4);

    // R9: trigger during a running burst is dropped
    start(3'd2, 2'd3, 8'd15);
    measure(2 * TRIG);
    chk(n_en == 256, "R9 dropped trigger en", n_en, 256);
    chk(n_clp == 128, "R9 dropped trigger clamp", n_clp, 128);
    measure(1);
    chk(code_now() == 1 && drv_en, "R9 R1 burst after drop", code_now(), 1);

    // R6: full continuous enable window repeats
    start(3'd4, 2'd1, 8'd2);
    measure(CWP);
    chk(n_en == CWP / 10, "R6 en duty", n_en, CWP / 10);
    measure(1);
    chk(drv_en == 1'b1, "R6 en restart", drv_en, 1);

    // R8: stop mid burst
    start(3'd2, 2'd3, 8'd3);
    measure(10);
    @(negedge clk); run = 1'b0;
    @(posedge clk); #1;
    chk({drv_pos, drv_neg, drv_en, clamp_on} == 4'b0, "R8 stop", {drv_pos, drv_neg, drv_en, clamp_on}, 0);

    // R10: reset mid burst
    start(3'd0, 2'd3, 8'd3);
    measure(7);
    @(negedge clk); rst_n = 1'b0; #1;
    chk({drv_pos, drv_neg, drv_en, clamp_on} == 4'b0, "R10 reset mid", {drv_pos, drv_neg, drv_en, clamp_on}, 0);
    @(negedge clk); rst_n = 1'b1; run = 1'b0;
    repeat (2) @(posedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule